// File: doc/BRIEF.md
# Supply-Crossing Interrupt Filter

This block is the digital back end of a supply-voltage monitor. An analog comparator outside the block drives a level that is high while the supply is at or above a threshold and low while it is below. That level arrives asynchronously. The block synchronizes it, then filters it on a sampling strobe whose rate is a selectable fraction of the block clock. Only a level that holds for four consecutive samples is accepted. Each accepted change, in either direction, sets a sticky detection flag. The flag stays set until software clears it.

The rising edge of the flag raises a one-cycle interrupt request, provided that the request is enabled, the interrupt use is selected, the low-speed internal oscillator is selected and the chip is not in stop mode. The request is ORed with the watchdog and oscillation-stop requests onto one shared vector line. The control bits come from a register file elsewhere in the chip. The flag is its read-back.

Top module: `svd_irq_top`

## Requirements
- R1: With `filt_sel` = 00, a change of `cmp_async` made just after a rising clock edge k sets `det_flag` at rising edge k+6. The delay is two synchronizer stages plus four samples, and the flag then reads 1.
- R2: Both a 0-to-1 and a 1-to-0 change of the filtered comparator level set `det_flag`.
- R3: `filt_sel` codes 00, 01, 10 and 11 give one sample every 1, 2, 4 and 8 clocks. With divisor d, the flag sets between 3+3d and 2+4d clocks after the input change.
- R4: A comparator level that is seen on fewer than four consecutive samples does not set the flag. It also restarts the count, so a later lasting change still needs a full four samples.
- R5: `det_flag` stays 1 until a one-cycle pulse on `flag_clr`. The flag reads 0 on the edge after that pulse.
- R6: The detection request is a single-cycle pulse, issued only on the cycle in which `det_flag` goes from 0 to 1. A further accepted crossing while the flag is already 1 issues nothing.
- R7: A request is issued only if `irq_en` = 1, `src_sel` = 0 (interrupt use) and `osc_sel` = 0 (low-speed internal oscillator). The flag sets regardless of these bits.
- R8: `pwr_mode` encodes 00 as normal, 01 as wait, and 10 or 11 as stop. A request is issued in normal and wait modes, and none is issued in stop mode.
- R9: While `det_en` = 0 the flag does not set, and the filter tracks the synchronized level. Enabling the block with a comparator level different from the earlier one gives no detection.
- R10: `vec_irq` is 1 whenever the detection request, `wdt_irq` or `osc_stop_irq` is 1.
- R11: After reset, `det_flag` and `vec_irq` are 0 while the inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the base of the sampling strobe |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_async | input | 1 | Asynchronous comparator level, 1 when the supply is at or above the threshold |
| det_en | input | 1 | Detection circuit enable |
| irq_en | input | 1 | Detection interrupt enable |
| src_sel | input | 1 | Use select, 0 selects the interrupt |
| osc_sel | input | 1 | Oscillator select, 0 means the low-speed internal oscillator |
| pwr_mode | input | 2 | 00 normal, 01 wait, 1x stop |
| filt_sel | input | FSEL_W | Sampling divisor select, divisor is 2^filt_sel |
| flag_clr | input | 1 | Software clear pulse for the detection flag |
| wdt_irq | input | 1 | Watchdog request sharing the vector |
| osc_stop_irq | input | 1 | Oscillation-stop request sharing the vector |
| det_flag | output | 1 | Sticky detection flag |
| vec_irq | output | 1 | Shared interrupt vector request |

## Verification
The hardest case to reach from the ports is a lasting change that directly follows a short glitch. It is the only way to show that an unfinished count is discarded rather than kept. The stimulus holds the comparator for three clocks, one sample short of acceptance. It then makes a real change and requires the exact six-clock latency. For the slower divisors the strobe phase cannot be seen at the ports. The bench therefore resets the divider by toggling the enable, and it accepts any latency inside the window that the divisor allows.

// File: rtl/svd_pkg.sv
package svd_pkg;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'b00,
    PWR_WAIT   = 2'b01,
    PWR_STOP   = 2'b10,
    PWR_STOP_X = 2'b11
  } pwr_mode_e;

  // Stop mode suppresses the detection request.
  function automatic logic mode_allows_req(input pwr_mode_e m);
    return (m == PWR_NORMAL) || (m == PWR_WAIT);
  endfunction

endpackage

// File: rtl/svd_rst_sync.sv
module svd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/svd_sync.sv
module svd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], d_async};
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/svd_sample_div.sv
module svd_sample_div #(
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FSEL_W-1:0] fsel,
  output logic              stb
);

  localparam int MAX_SHIFT = (1 << FSEL_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, lim;

  // Terminal count is 2^fsel - 1: the low fsel bits set.
  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(fsel)) lim[i] = 1'b1;
    end
  end

  // A compare of >= keeps a lowered divisor from running past its limit.
  assign stb = en && (cnt_q >= lim);

  always_comb begin
    if (!en)      cnt_n = '0;
    else if (stb) cnt_n = '0;
    else          cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/svd_filter.sv
module svd_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic din,
  output logic lvl,
  output logic evt
);

  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  logic          lvl_q, lvl_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    lvl_n = lvl_q;
    cnt_n = cnt_q;
    evt   = 1'b0;
    if (!en) begin
      // Track the input while disabled so that enabling sees no change.
      lvl_n = din;
      cnt_n = '0;
    end else if (stb) begin
      if (din != lvl_q) begin
        if (cnt_q == LAST) begin
          lvl_n = din;
          cnt_n = '0;
          evt   = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_n;
      cnt_q <= cnt_n;
    end
  end

  assign lvl = lvl_q;

endmodule

// File: rtl/svd_irq_top.sv
module svd_irq_top
  import svd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 4,
  parameter int FSEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_async,
  input  logic              det_en,
  input  logic              irq_en,
  input  logic              src_sel,
  input  logic              osc_sel,
  input  logic [1:0]        pwr_mode,
  input  logic [FSEL_W-1:0] filt_sel,
  input  logic              flag_clr,
  input  logic              wdt_irq,
  input  logic              osc_stop_irq,
  output logic              det_flag,
  output logic              vec_irq
);

  logic rst_sync_n;
  logic cmp_s;
  logic smp_stb;
  logic filt_lvl;
  logic filt_evt;

  logic flag_q, flag_n;
  logic det_req_q, det_req_n;
  logic flag_set;
  logic req_gate;

  svd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  svd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (cmp_async),
    .q_sync  (cmp_s)
  );

  svd_sample_div #(.FSEL_W(FSEL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (det_en),
    .fsel  (filt_sel),
    .stb   (smp_stb)
  );

  svd_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (det_en),
    .stb   (smp_stb),
    .din   (cmp_s),
    .lvl   (filt_lvl),
    .evt   (filt_evt)
  );

  assign flag_set = filt_evt & det_en;
  assign req_gate = irq_en & ~src_sel & ~osc_sel & mode_allows_req(pwr_mode_e'(pwr_mode));

  always_comb begin
    if (flag_set)      flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    else               flag_n = flag_q;
    det_req_n = flag_set & ~flag_q & req_gate;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q    <= 1'b0;
      det_req_q <= 1'b0;
    end else begin
      flag_q    <= flag_n;
      det_req_q <= det_req_n;
    end
  end

  assign det_flag = flag_q;
  assign vec_irq  = det_req_q | wdt_irq | osc_stop_irq;

endmodule

// File: rtl/svd_irq_chk.sv
module svd_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       det_en,
  input logic       irq_en,
  input logic       src_sel,
  input logic       osc_sel,
  input logic [1:0] pwr_mode,
  input logic       flag_clr,
  input logic       wdt_irq,
  input logic       osc_stop_irq,
  input logic       det_flag,
  input logic       vec_irq,
  input logic       det_req,
  input logic       filt_evt,
  input logic       filt_lvl,
  input logic       smp_stb
);

  p_flag_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(filt_evt));

  p_lvl_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> ($past(smp_stb) || !$past(det_en)));

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_flag) |-> $past(flag_clr));

  p_req_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_req |-> $rose(det_flag));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_req |=> !det_req);

  p_req_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_req |-> ($past(irq_en) && !$past(src_sel) && !$past(osc_sel)));

  p_req_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_req |-> !$past(pwr_mode[1]));

  p_set_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(det_en));

  p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_req || wdt_irq || osc_stop_irq) |-> vec_irq);

endmodule

bind svd_irq_top svd_irq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .det_en       (det_en),
  .irq_en       (irq_en),
  .src_sel      (src_sel),
  .osc_sel      (osc_sel),
  .pwr_mode     (pwr_mode),
  .flag_clr     (flag_clr),
  .wdt_irq      (wdt_irq),
  .osc_stop_irq (osc_stop_irq),
  .det_flag     (det_flag),
  .vec_irq      (vec_irq),
  .det_req      (det_req_q),
  .filt_evt     (filt_evt),
  .filt_lvl     (filt_lvl),
  .smp_stb      (smp_stb)
);

// File: tb/svd_irq_top_tb.sv
module svd_irq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_async, det_en, irq_en, src_sel, osc_sel;
  logic [1:0] pwr_mode;
  logic [1:0] filt_sel;
  logic       flag_clr, wdt_irq, osc_stop_irq;
  logic       det_flag, vec_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic prev_flag = 1'b0;
  logic finished  = 1'b0;

  typedef struct {
    int    start;
    int    lo;
    int    hi;
    logic  irq;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  svd_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_async(cmp_async), .det_en(det_en),
    .irq_en(irq_en), .src_sel(src_sel), .osc_sel(osc_sel),
    .pwr_mode(pwr_mode), .filt_sel(filt_sel), .flag_clr(flag_clr),
    .wdt_irq(wdt_irq), .osc_stop_irq(osc_stop_irq),
    .det_flag(det_flag), .vec_irq(vec_irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: a flag rise pops one expected item; a request without a rise is stray.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (det_flag && !prev_flag) begin
        if (sb_q.size() == 0) begin
          check("R6/R9 unexpected flag rise", 1, 0);
        end else begin
          exp_t e;
          int lat;
          e   = sb_q.pop_front();
          lat = cyc - e.start;
          check({e.tag, " latency in window"}, int'(lat >= e.lo && lat <= e.hi), 1);
          check({e.tag, " request"}, int'(vec_irq), int'(e.irq));
        end
      end else if (vec_irq && !wdt_irq && !osc_stop_irq) begin
        check("R6 stray request", 1, 0);
      end
      prev_flag <= det_flag;
    end
  end

  task automatic crossing(input logic lvl, input int lo, input int hi,
                          input logic irq, input string tag);
    exp_t e;
    @(negedge clk);
    e.start = cyc; e.lo = lo; e.hi = hi; e.irq = irq; e.tag = tag;
    sb_q.push_back(e);
    cmp_async = lvl;
    repeat (hi + 3) @(negedge clk);
    if (sb_q.size() != 0) begin
      check({tag, " flag never set"}, 0, 1);
      void'(sb_q.pop_front());
    end
  endtask

  task automatic quiet(input int n, input logic exp_flag, input string tag);
    repeat (n) @(negedge clk);
    check(tag, int'(det_flag), int'(exp_flag));
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R5 flag cleared by software", int'(det_flag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_async = 1'b0; det_en = 1'b0; irq_en = 1'b0;
    src_sel = 1'b0; osc_sel = 1'b0; pwr_mode = 2'b00; filt_sel = 2'b00;
    flag_clr = 1'b0; wdt_irq = 1'b0; osc_stop_irq = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 flag after reset", int'(det_flag), 0);
    check("R11 vector after reset", int'(vec_irq), 0);

    det_en = 1'b1; irq_en = 1'b1;
    repeat (5) @(negedge clk);
    crossing(1'b1, 6, 6, 1'b1, "R1 rising crossing div1");
    quiet(12, 1'b1, "R5 flag sticky");
    clear_flag();
    crossing(1'b0, 6, 6, 1'b1, "R2 falling crossing");
    clear_flag();

    // Three clocks high: one sample short.
    @(negedge clk); cmp_async = 1'b1;
    repeat (3) @(negedge clk); cmp_async = 1'b0;
    quiet(20, 1'b0, "R4 short glitch ignored");
    crossing(1'b1, 6, 6, 1'b1, "R4 count restarted after glitch");

    // Crossing back while the flag is held: no new request.
    @(negedge clk); cmp_async = 1'b0;
    quiet(20, 1'b1, "R6 held flag no new request");
    clear_flag();

    irq_en = 1'b0;
    crossing(1'b1, 6, 6, 1'b0, "R7 request disabled");
    clear_flag();
    irq_en = 1'b1; src_sel = 1'b1;
    crossing(1'b0, 6, 6, 1'b0, "R7 alternative use selected");
    clear_flag();
    src_sel = 1'b0; osc_sel = 1'b1;
    crossing(1'b1, 6, 6, 1'b0, "R7 other oscillator");
    clear_flag();
    osc_sel = 1'b0;

    pwr_mode = 2'b01;
    crossing(1'b0, 6, 6, 1'b1, "R8 wait mode");
    clear_flag();
    pwr_mode = 2'b10;
    crossing(1'b1, 6, 6, 1'b0, "R8 stop mode");
    clear_flag();
    pwr_mode = 2'b00;

    @(negedge clk); det_en = 1'b0; filt_sel = 2'b01;
    repeat (3) @(negedge clk); det_en = 1'b1;
    crossing(1'b0, 9, 10, 1'b1, "R3 divide by 2");
    clear_flag();
    filt_sel = 2'b10;
    crossing(1'b1, 15, 18, 1'b1, "R3 divide by 4");
    clear_flag();
    filt_sel = 2'b11;
    crossing(1'b0, 27, 34, 1'b1, "R3 divide by 8");
    clear_flag();

    filt_sel = 2'b00;
    @(negedge clk); det_en = 1'b0; cmp_async = 1'b1;
    quiet(20, 1'b0, "R9 no flag while disabled");
    det_en = 1'b1;
    quiet(20, 1'b0, "R9 no spurious on enable");
    crossing(1'b0, 6, 6, 1'b1, "R9 detection after enable");
    clear_flag();

    @(negedge clk); #1 wdt_irq = 1'b1; #1;
    check("R10 watchdog on vector", int'(vec_irq), 1);
    wdt_irq = 1'b0; osc_stop_irq = 1'b1; #1;
    check("R10 oscillation stop on vector", int'(vec_irq), 1);
    osc_stop_irq = 1'b0; #1;
    check("R10 vector idle", int'(vec_irq), 0);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule